// File: doc/BRIEF.md
# Two-Digit Minute Countdown Timer

This block runs a device for a chosen number of whole minutes, from 00 to 99. The duration is entered as two decimal digits. One button steps the tens digit and another steps the units digit, and each digit wraps from 9 back to 0. A single start/stop button either begins a run or cancels one that is in progress. While a run is active, the enable output is high and the two digit outputs show the minutes still remaining in BCD.

A run can end in two ways. It ends normally when its last minute completes, and it is cancelled by a stop press. Either way the enable drops, both digits return to zero and the block is ready for a new setting. A one-cycle pulse marks each kind of ending. Outside the block, a prescaler supplies a one-clock enable once per second, and the buttons arrive already debounced as one-clock press pulses.

Top module: `mincount_timer`

## Requirements
- R1: After reset, `dev_on`, `done_pulse` and `abort_pulse` are 0 and both digit outputs read 0.
- R2: While idle, a `units_btn` pulse advances `digit_units` by one in the next cycle. The digit is BCD (0 to 9) and wraps from 9 to 0.
- R3: While idle, a `tens_btn` pulse advances `digit_tens` the same way, with the same wrap from 9 to 0.
- R4: While idle, a `startstop_btn` pulse starts a run (`dev_on` = 1 in the next cycle) only when the setting is not 00. A press at 00 is ignored.
- R5: Digit buttons have no effect during a run. While idle, digit presses that arrive in the same cycle as a start/stop press are dropped.
- R6: During a run, every `tick_1s` pulse counts one second. After TICKS_PER_MIN ticks (default 60), the displayed value drops by one minute in the next cycle, with a decimal borrow (10 becomes 09). Ticks while idle are ignored.
- R7: When the tick that completes the last minute arrives, the next cycle shows `dev_on` = 0, both digits 0, and `done_pulse` high for exactly one cycle.
- R8: A start/stop press during a run aborts it. The next cycle shows `dev_on` = 0, both digits 0, and `abort_pulse` high for one cycle with no `done_pulse`. The abort wins over an expiry in the same cycle.
- R9: Each run starts with a fresh second count. Seconds left over from an aborted run, or ticks received while idle, do not shorten the first minute.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1s | input | 1 | One-clock enable, once per second |
| units_btn | input | 1 | Units digit step press (one-clock pulse) |
| tens_btn | input | 1 | Tens digit step press (one-clock pulse) |
| startstop_btn | input | 1 | Start or abort press (one-clock pulse) |
| dev_on | output | 1 | High while a run is active |
| digit_tens | output | 4 | Tens digit, BCD |
| digit_units | output | 4 | Units digit, BCD |
| done_pulse | output | 1 | One-cycle pulse on normal expiry |
| abort_pulse | output | 1 | One-cycle pulse on abort |

## Verification
The bench targets several corner cases. A start press at 00 must be ignored; a design that accepted it would raise the enable for a run that can never expire. A stop press that lands in the same cycle as the final tick must report an abort only, not a done or both. A tens borrow from 10 to 09 is checked, because a design that decremented only the units digit would show 1F or 19. A one-minute run that follows an abort made halfway through a minute is also timed; a design that kept the old seconds count would expire up to 59 ticks early.

// File: rtl/mct_pkg.sv
package mct_pkg;
  localparam int DIGIT_W   = 4;
  localparam int DIGIT_MAX = 9;

  typedef enum logic {
    ST_SET = 1'b0,
    ST_RUN = 1'b1
  } run_state_e;
endpackage

// File: rtl/mct_bcd_digit.sv
module mct_bcd_digit
  import mct_pkg::*;
#(
  parameter int MAX = DIGIT_MAX
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               inc,
  input  logic               dec,
  output logic [DIGIT_W-1:0] val,
  output logic               at_zero
);
  localparam logic [DIGIT_W-1:0] TOP = DIGIT_W'(MAX);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      val <= '0;
    end else if (inc) begin
      val <= (val == TOP) ? '0 : val + 1'b1;
    end else if (dec) begin
      val <= (val == '0) ? TOP : val - 1'b1;
    end
  end

  assign at_zero = (val == '0);

  p_digit_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    val <= TOP);
  p_digit_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr && val == TOP) |=> (val == '0));
endmodule

// File: rtl/mct_sec_count.sv
module mct_sec_count #(
  parameter int TICKS = 60
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic tick,
  output logic min_wrap
);
  localparam int CW = (TICKS > 2) ? $clog2(TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end
  end

  assign min_wrap = tick && (cnt == LAST);

  p_sec_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);
  p_sec_cleared_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0));
endmodule

// File: rtl/mct_ctrl.sv
module mct_ctrl
  import mct_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ss_btn,
  input  logic               units_btn,
  input  logic               tens_btn,
  input  logic               min_wrap,
  input  logic [DIGIT_W-1:0] tens_val,
  input  logic [DIGIT_W-1:0] units_val,
  input  logic               tens_zero,
  input  logic               units_zero,
  output logic               units_inc,
  output logic               units_dec,
  output logic               tens_inc,
  output logic               tens_dec,
  output logic               digits_clr,
  output logic               sec_clr,
  output logic               running,
  output logic               done_q,
  output logic               abort_q
);
  run_state_e state, state_nx;
  logic value_nz, last_min, start_ok, abort_now, expire_now, step_down;

  assign running    = (state == ST_RUN);
  assign value_nz   = !(tens_zero && units_zero);
  assign last_min   = tens_zero && (units_val == DIGIT_W'(1));
  assign start_ok   = !running && ss_btn && value_nz;
  assign abort_now  = running && ss_btn;
  assign expire_now = running && !ss_btn && min_wrap && last_min;
  assign step_down  = running && !ss_btn && min_wrap && !last_min;

  assign units_inc  = !running && !ss_btn && units_btn;
  assign tens_inc   = !running && !ss_btn && tens_btn;
  assign units_dec  = step_down;
  assign tens_dec   = step_down && units_zero;
  assign digits_clr = abort_now || expire_now;
  assign sec_clr    = !running;

  always_comb begin
    state_nx = state;
    if (start_ok)                     state_nx = ST_RUN;
    else if (abort_now || expire_now) state_nx = ST_SET;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_SET;
      done_q  <= 1'b0;
      abort_q <= 1'b0;
    end else begin
      state   <= state_nx;
      done_q  <= expire_now;
      abort_q <= abort_now;
    end
  end

  p_zero_start_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && ss_btn && tens_val == '0 && units_val == '0) |=> !running);
  p_digits_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !ss_btn && !min_wrap) |=> ($stable(tens_val) && $stable(units_val)));
  p_single_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_q && abort_q));
endmodule

// File: rtl/mincount_timer.sv
module mincount_timer
  import mct_pkg::*;
#(
  parameter int TICKS_PER_MIN = 60
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick_1s,
  input  logic               units_btn,
  input  logic               tens_btn,
  input  logic               startstop_btn,
  output logic               dev_on,
  output logic [DIGIT_W-1:0] digit_tens,
  output logic [DIGIT_W-1:0] digit_units,
  output logic               done_pulse,
  output logic               abort_pulse
);
  logic units_inc, units_dec, tens_inc, tens_dec, digits_clr, sec_clr;
  logic min_wrap, tens_zero, units_zero;

  mct_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .ss_btn     (startstop_btn),
    .units_btn  (units_btn),
    .tens_btn   (tens_btn),
    .min_wrap   (min_wrap),
    .tens_val   (digit_tens),
    .units_val  (digit_units),
    .tens_zero  (tens_zero),
    .units_zero (units_zero),
    .units_inc  (units_inc),
    .units_dec  (units_dec),
    .tens_inc   (tens_inc),
    .tens_dec   (tens_dec),
    .digits_clr (digits_clr),
    .sec_clr    (sec_clr),
    .running    (dev_on),
    .done_q     (done_pulse),
    .abort_q    (abort_pulse)
  );

  mct_sec_count #(.TICKS(TICKS_PER_MIN)) u_sec (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (sec_clr),
    .tick     (tick_1s),
    .min_wrap (min_wrap)
  );

  mct_bcd_digit #(.MAX(DIGIT_MAX)) u_units (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (digits_clr),
    .inc     (units_inc),
    .dec     (units_dec),
    .val     (digit_units),
    .at_zero (units_zero)
  );

  mct_bcd_digit #(.MAX(DIGIT_MAX)) u_tens (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (digits_clr),
    .inc     (tens_inc),
    .dec     (tens_dec),
    .val     (digit_tens),
    .at_zero (tens_zero)
  );

  p_run_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dev_on |-> (digit_tens != '0 || digit_units != '0));
  p_done_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |-> (!dev_on && digit_tens == '0 && digit_units == '0));
  p_abort_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    abort_pulse |-> (!dev_on && digit_tens == '0 && digit_units == '0));
  p_reset_idle_r1: assert property (@(posedge clk)
    !rst_n |=> (!dev_on && !done_pulse && !abort_pulse));
endmodule

// File: tb/test_mincount_timer.sv
module test_mincount_timer;
  localparam int T = 60;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_1s = 1'b0, units_btn = 1'b0, tens_btn = 1'b0, startstop_btn = 1'b0;
  logic dev_on, done_pulse, abort_pulse;
  logic [3:0] digit_tens, digit_units;

  always #10 clk = ~clk;

  mincount_timer #(.TICKS_PER_MIN(T)) i_mincount_timer (
    .clk(clk), .rst_n(rst_n), .tick_1s(tick_1s), .units_btn(units_btn),
    .tens_btn(tens_btn), .startstop_btn(startstop_btn), .dev_on(dev_on),
    .digit_tens(digit_tens), .digit_units(digit_units),
    .done_pulse(done_pulse), .abort_pulse(abort_pulse)
  );

  int checks = 0, fails = 0;
  int m_run = 0, m_t = 0, m_u = 0, m_sec = 0, m_done = 0, m_abort = 0;
  string cur_tag = "R1";
  int unsigned seed_init;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    chk(cur_tag, "dev_on", int'(dev_on), m_run);
    chk(cur_tag, "digit_tens", int'(digit_tens), m_t);
    chk(cur_tag, "digit_units", int'(digit_units), m_u);
    chk(cur_tag, "done_pulse", int'(done_pulse), m_done);
    chk(cur_tag, "abort_pulse", int'(abort_pulse), m_abort);
  endtask

  task automatic model(input bit ss, input bit un, input bit tn, input bit tk);
    int v;
    m_done = 0; m_abort = 0;
    if (m_run == 0) begin
      if (ss) begin
        if (m_t * 10 + m_u > 0) begin m_run = 1; m_sec = 0; end
      end else begin
        if (un) m_u = (m_u + 1) % 10;
        if (tn) m_t = (m_t + 1) % 10;
      end
    end else if (ss) begin
      m_run = 0; m_t = 0; m_u = 0; m_abort = 1;
    end else if (tk) begin
      if (m_sec == T - 1) begin
        m_sec = 0;
        v = m_t * 10 + m_u - 1;
        if (v == 0) begin m_run = 0; m_t = 0; m_u = 0; m_done = 1; end
        else begin m_t = v / 10; m_u = v % 10; end
      end else m_sec++;
    end
  endtask

  task automatic cyc(input bit ss, input bit un, input bit tn, input bit tk);
    compare();
    startstop_btn = ss; units_btn = un; tens_btn = tn; tick_1s = tk;
    model(ss, un, tn, tk);
    @(negedge clk);
  endtask

  task automatic set_value(input int t, input int u);
    for (int i = 0; i < t; i++) cyc(0, 0, 1, 0);
    for (int i = 0; i < u; i++) cyc(0, 1, 0, 0);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    seed_init = $urandom(32'd1234);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    cur_tag = "R1";
    cyc(0, 0, 0, 0);
    chk("R1", "dev_on after reset", int'(dev_on), 0);
    // R4 start at 00 ignored
    cur_tag = "R4";
    cyc(1, 0, 0, 0);
    cyc(0, 0, 0, 0);
    chk("R4", "dev_on on 00 start", int'(dev_on), 0);
    // R2 units wrap
    cur_tag = "R2";
    set_value(0, 12);
    chk("R2", "units after 12 presses", int'(digit_units), 2);
    // R3 tens wrap
    cur_tag = "R3";
    set_value(11, 0);
    chk("R3", "tens after 11 presses", int'(digit_tens), 1);
    // R5 start with simultaneous digit presses
    cur_tag = "R5";
    cyc(1, 1, 1, 0);
    chk("R5", "units after start+press", int'(digit_units), 2);
    chk("R4", "dev_on after start", int'(dev_on), 1);
    for (int i = 0; i < 5; i++) cyc(0, 1, 1, 0);
    chk("R5", "tens during run", int'(digit_tens), 1);
    // R6 minute step 12 -> 11
    cur_tag = "R6";
    ticks(T);
    chk("R6", "units after one minute", int'(digit_units), 1);
    ticks(30);
    // R8 abort mid-minute
    cur_tag = "R8";
    cyc(1, 0, 0, 0);
    chk("R8", "abort_pulse", int'(abort_pulse), 1);
    chk("R8", "tens cleared", int'(digit_tens), 0);
    // R9 fresh seconds, idle ticks ignored
    cur_tag = "R9";
    ticks(45);
    set_value(0, 1);
    cyc(1, 0, 0, 0);
    ticks(T - 1);
    chk("R9", "still running before full minute", int'(dev_on), 1);
    cur_tag = "R7";
    ticks(1);
    chk("R7", "done_pulse", int'(done_pulse), 1);
    chk("R7", "dev_on after expiry", int'(dev_on), 0);
    cyc(0, 0, 0, 0);
    chk("R7", "done one cycle", int'(done_pulse), 0);
    // R8 abort coincides with final tick
    cur_tag = "R8";
    set_value(0, 1);
    cyc(1, 0, 0, 0);
    ticks(T - 1);
    cyc(1, 0, 0, 1);
    chk("R8", "abort wins", int'(abort_pulse), 1);
    chk("R8", "no done on abort", int'(done_pulse), 0);
    // R6 borrow 10 -> 09
    cur_tag = "R6";
    set_value(1, 0);
    cyc(1, 0, 0, 0);
    ticks(T);
    chk("R6", "borrow tens", int'(digit_tens), 0);
    chk("R6", "borrow units", int'(digit_units), 9);
    cyc(1, 0, 0, 0);
    // random phase
    cur_tag = "R6";
    for (int i = 0; i < 60000; i++) begin
      if (m_run == 0)
        cyc(($urandom % 10) == 0, ($urandom % 4) == 0, ($urandom % 6) == 0, ($urandom % 2) == 0);
      else
        cyc(($urandom % 3000) == 0, ($urandom % 3) == 0, ($urandom % 3) == 0, ($urandom % 4) != 0);
    end
    compare();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule